// File: doc/BRIEF.md
# Parallel-Port Task-File Register Accessor

This block gives a host-side controller single-register access to the ATA task-file registers of a storage bridge that sits on a plain parallel port. It drives only the port's 8-bit data output and its control output. Read data comes back through the upper four status input lines, one nibble at a time. A user request carries a register index, a read/write flag and a write byte. The block runs the fixed port sequence for that access and pulses `done` when it finishes. For reads, it returns the assembled byte on `rd_data`.

The status inputs can be taken as they are (direct mode) or passed through a remap stage. The remap stage moves the lines of a non-standard adapter into standard bit positions and inverts the one line whose sense is reversed. Every port update is held for a programmable number of settle cycles before the block takes the next step or samples the status. Only one access runs at a time.

Top module: `ppreg_bridge_access`

## Requirements
- R1: After reset `ready`=1, `done`=0, `rd_data`=0x00, `pp_data`=0x00 and `pp_ctrl`=4.
- R2: A write to index i runs four port steps in order: data=0x60+i with control still 4; control=1; data=write byte; control=4.
- R3: A read of index i runs four port steps in order: data=i with control still 4; control=1; control=3; control=4.
- R4: A read returns status bits [7:4] (after the mode stage), sampled at the end of the control=3 step, as `rd_data[3:0]`. It returns the same bits sampled at the end of the control=4 step as `rd_data[7:4]`.
- R5: With `remap_en`=1, raw bit 0 goes to standard bit 6, raw bit 2 to bit 5, raw bit 3 to bit 4 and raw bit 4 to bit 3. Standard bits 2..0 are 0.
- R6: With `remap_en`=1, standard bit 7 is the inverse of raw bit 1, so a raw 0 gives a 1.
- R7: With `remap_en`=0, the status byte is used unchanged.
- R8: With settle value S, each of the four steps lasts S+1 cycles. `done` is high in the cycle that follows the clock edge 4(S+1) edges after the accepting edge.
- R9: `ready` is low from the accepting edge until the access ends. A request presented while `ready` is low is ignored: it does not alter the running sequence and does not start another access.
- R10: `done` is a one-cycle pulse. `rd_data` changes only when a read completes, and a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when `ready` is high |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_index | input | IDX_W | Task-file register index |
| req_wdata | input | 8 | Byte to write |
| remap_en | input | 1 | 1 = remap adapter status lines, 0 = direct |
| settle_cycles | input | SETTLE_W | Extra hold cycles per port step |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| pp_data | output | 8 | Parallel-port data output |
| pp_ctrl | output | 4 | Parallel-port control output code |
| pp_status | input | 8 | Raw parallel-port status inputs |

## Verification
The assertions assume that `settle_cycles` and `remap_en` stay constant while an access runs. They also assume that the status lines are steady over the step in which they are sampled. The timer and the nibble capture depend on both. The stimulus changes the mode and the settle value only while the block is idle. It drives the status lines as a function of the control code, so the low-nibble pattern is present throughout the control=3 step and the high-nibble pattern throughout the control=4 step. The one stray request is presented mid-access, to show that a busy block drops it.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;

    localparam int PORT_W = 8;
    localparam int CTRL_W = 4;

    localparam logic [CTRL_W-1:0] CTL_SELECT = 4'd1;
    localparam logic [CTRL_W-1:0] CTL_STROBE = 4'd3;
    localparam logic [CTRL_W-1:0] CTL_REST   = 4'd4;
    localparam logic [PORT_W-1:0] WR_OFFSET  = 8'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SEL,
        ST_MID,
        ST_LAST
    } step_t;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [CTRL_W-1:0] ctrl;
    } port_t;

    typedef struct packed {
        logic       write;
        logic [7:0] index;
        logic [7:0] wbyte;
    } access_t;

    // Adapter line order to standard status order, one inverted line.
    function automatic logic [7:0] adapter_to_std(input logic [7:0] raw);
        logic [7:0] s;
        s    = '0;
        s[7] = ~raw[1];
        s[6] = raw[0];
        s[5] = raw[2];
        s[4] = raw[3];
        s[3] = raw[4];
        return s;
    endfunction

endpackage

// File: rtl/ppreg_status_map.sv
module ppreg_status_map
    import ppreg_pkg::*;
(
    input  logic       remap_en,
    input  logic [7:0] raw,
    output logic [3:0] nibble
);
    logic [7:0] std_byte;

    always_comb begin
        std_byte = remap_en ? adapter_to_std(raw) : raw;
        nibble   = std_byte[7:4];
    end

    // R5: unmapped standard bits stay clear in remap mode
    always_comb begin
        if (remap_en)
            a_r5_unmapped_clear: assert (std_byte[2:0] == 3'b000);
    end

    // R6: the reversed line arrives inverted
    always_comb begin
        if (remap_en)
            a_r6_busy_inverted: assert (nibble[3] == !raw[1]);
    end

endmodule

// File: rtl/ppreg_settle_timer.sv
module ppreg_settle_timer #(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic [SETTLE_W-1:0] limit,
    output logic                expired
);
    logic [SETTLE_W-1:0] cnt;

    assign expired = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    // R8: a running window advances by exactly one per cycle
    a_r8_timer_steps: assert property (@(posedge clk) disable iff (rst)
        (!restart && !expired) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ppreg_sequencer.sv
module ppreg_sequencer
    import ppreg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic [7:0]       req_wdata,
    input  logic             expired,
    input  logic [3:0]       status_nib,
    output logic             restart,
    output logic             ready,
    output logic             done,
    output logic [7:0]       rd_data,
    output port_t            port
);
    localparam int PAD_W = PORT_W - IDX_W;

    step_t      step;
    access_t    cur;
    logic [3:0] low_hold;
    logic       accept;
    logic       advance;
    logic [7:0] idx_wide;

    assign idx_wide = {{PAD_W{1'b0}}, req_index};
    assign ready    = (step == ST_IDLE);
    assign accept   = req_valid && ready;
    assign advance  = !ready && expired;
    assign restart  = accept || advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_IDLE;
            cur      <= '0;
            low_hold <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
            port     <= '{data: '0, ctrl: CTL_REST};
        end else begin
            done <= 1'b0;
            if (accept) begin
                cur       <= '{write: req_write, index: idx_wide, wbyte: req_wdata};
                step      <= ST_ADDR;
                port.data <= req_write ? (WR_OFFSET + idx_wide) : idx_wide;
            end else if (advance) begin
                case (step)
                    ST_ADDR: begin
                        step      <= ST_SEL;
                        port.ctrl <= CTL_SELECT;
                    end
                    ST_SEL: begin
                        step <= ST_MID;
                        if (cur.write)
                            port.data <= cur.wbyte;
                        else
                            port.ctrl <= CTL_STROBE;
                    end
                    ST_MID: begin
                        step      <= ST_LAST;
                        port.ctrl <= CTL_REST;
                        if (!cur.write)
                            low_hold <= status_nib;
                    end
                    ST_LAST: begin
                        step <= ST_IDLE;
                        done <= 1'b1;
                        if (!cur.write)
                            rd_data <= {status_nib, low_hold};
                    end
                    default: step <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion is reported with the block idle again
    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    // R2 R3: only the three defined control codes appear
    a_r3_ctrl_codes: assert property (@(posedge clk) disable iff (rst)
        (port.ctrl == CTL_SELECT) || (port.ctrl == CTL_STROBE) || (port.ctrl == CTL_REST));

    // R8: the port moves only when a step opens
    a_r8_port_holds: assert property (@(posedge clk) disable iff (rst)
        (port != $past(port)) |-> $past(restart));

    // R9: a busy block keeps the access it latched
    a_r9_busy_keeps_access: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (cur == $past(cur)));

    // R10: read data changes only on a completing read
    a_r10_rd_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_data != $past(rd_data)) |-> done);

endmodule

// File: rtl/ppreg_bridge_access.sv
module ppreg_bridge_access
    import ppreg_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [IDX_W-1:0]    req_index,
    input  logic [7:0]          req_wdata,
    input  logic                remap_en,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                ready,
    output logic                done,
    output logic [7:0]          rd_data,
    output logic [7:0]          pp_data,
    output logic [3:0]          pp_ctrl,
    input  logic [7:0]          pp_status
);
    logic       restart;
    logic       expired;
    logic [3:0] status_nib;
    port_t      port;

    ppreg_status_map u_map (
        .remap_en (remap_en),
        .raw      (pp_status),
        .nibble   (status_nib)
    );

    ppreg_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (settle_cycles),
        .expired (expired)
    );

    ppreg_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_index  (req_index),
        .req_wdata  (req_wdata),
        .expired    (expired),
        .status_nib (status_nib),
        .restart    (restart),
        .ready      (ready),
        .done       (done),
        .rd_data    (rd_data),
        .port       (port)
    );

    assign pp_data = port.data;
    assign pp_ctrl = port.ctrl;

endmodule

// File: tb/test_ppreg_bridge_access.sv
module test_ppreg_bridge_access;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_write, remap_en;
    logic [3:0] req_index, settle_cycles;
    logic [7:0] req_wdata, rd_data, pp_data, pp_status;
    logic [3:0] pp_ctrl;
    logic       ready, done;
    logic [7:0] st_lo, st_hi;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] exp_rd = 8'h00;

    always #5 clk = ~clk;

    assign pp_status = (pp_ctrl == 4'd3) ? st_lo : st_hi;

    ppreg_bridge_access i_ppreg_bridge_access (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .remap_en(remap_en),
        .settle_cycles(settle_cycles), .ready(ready), .done(done),
        .rd_data(rd_data), .pp_data(pp_data), .pp_ctrl(pp_ctrl),
        .pp_status(pp_status)
    );

    // {write, remap, index, wbyte, raw low-step status, raw high-step status, settle}
    localparam int NV = 7;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'h5, 8'hA5, 8'h00, 8'h00, 4'd0},
        {1'b0, 1'b0, 4'h3, 8'h00, 8'hC0, 8'h50, 4'd0},
        {1'b0, 1'b1, 4'hF, 8'h00, 8'h1D, 8'h02, 4'd2},
        {1'b0, 1'b1, 4'h0, 8'h00, 8'h00, 8'hE1, 4'd1},
        {1'b1, 1'b1, 4'hF, 8'h3C, 8'hFF, 8'hFF, 4'd3},
        {1'b0, 1'b0, 4'h7, 8'h00, 8'h3F, 8'hA0, 4'd1},
        {1'b0, 1'b1, 4'h9, 8'h00, 8'h04, 8'h0A, 4'd0}
    };

    function automatic logic [3:0] upper_std(input logic rm, input logic [7:0] raw);
        // R5 R6 R7: standard bit 7 = !raw1, 6 = raw0, 5 = raw2, 4 = raw3
        if (rm) return {~raw[1], raw[0], raw[2], raw[3]};
        return raw[7:4];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic run_access(input logic wr, input logic rm, input logic [3:0] idx,
                              input logic [7:0] wd, input logic [7:0] lo, input logic [7:0] hi,
                              input logic [3:0] s, input logic intrude);
        logic [7:0] ed [4];
        logic [3:0] ec [4];
        string tg;
        tg = wr ? "R2" : "R3";
        if (wr) begin
            ed = '{8'h60 + {4'h0, idx}, 8'h60 + {4'h0, idx}, wd, wd};
            ec = '{4'd4, 4'd1, 4'd1, 4'd4};
        end else begin
            ed = '{{4'h0, idx}, {4'h0, idx}, {4'h0, idx}, {4'h0, idx}};
            ec = '{4'd4, 4'd1, 4'd3, 4'd4};
        end
        remap_en = rm; settle_cycles = s; st_lo = lo; st_hi = hi;
        req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) begin
                repeat (s + 1) @(posedge clk);
                @(negedge clk);
                req_valid = 1'b0;
            end
            check({tg, " R8 data step"}, pp_data, ed[k]);
            check({tg, " R8 ctrl step"}, pp_ctrl, ec[k]);
            check("R9 ready low while busy", ready, 1'b0);
            check("R10 no early done", done, 1'b0);
            if (intrude && k == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_index = 4'hA; req_wdata = 8'h77;
            end
        end
        repeat (s + 1) @(posedge clk);
        @(negedge clk);
        if (!wr)
            exp_rd = {upper_std(rm, hi), upper_std(rm, lo)};
        check("R8 done after 4(S+1) edges", done, 1'b1);
        check("R9 ready at end", ready, 1'b1);
        check(wr ? "R10 write keeps rd_data" : "R4 R5 R6 R7 read data", rd_data, exp_rd);
        @(negedge clk);
        check("R10 done one cycle", done, 1'b0);
        check("R9 no extra access", pp_ctrl, 4'd4);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
        req_wdata = '0; remap_en = 1'b0; settle_cycles = '0; st_lo = '0; st_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready", ready, 1'b1);
        check("R1 done", done, 1'b0);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pp_data", pp_data, 8'h00);
        check("R1 pp_ctrl", pp_ctrl, 4'd4);
        repeat (2) @(negedge clk);
        check("R1 idle stays put", pp_ctrl, 4'd4);

        for (int v = 0; v < NV; v++) begin
            run_access(VEC[v][33], VEC[v][32], VEC[v][31:28], VEC[v][27:20],
                       VEC[v][19:12], VEC[v][11:4], VEC[v][3:0], 1'b0);
            @(negedge clk);
        end

        // R9: stray write request during a read is dropped
        run_access(1'b0, 1'b0, 4'h2, 8'h00, 8'h90, 8'h60, 4'd2, 1'b1);
        @(negedge clk);
        check("R9 idle after dropped request", ready, 1'b1);
        // R8: largest settle value, remap with all raw lines high
        run_access(1'b0, 1'b1, 4'hE, 8'h00, 8'hFF, 8'h1F, 4'd15, 1'b0);
        // R2: write at the highest index after a read
        run_access(1'b1, 1'b0, 4'hF, 8'h00, 8'h00, 8'h00, 4'd1, 1'b0);
        finish_run();
    end

endmodule